// File: doc/BRIEF.md
# Lane-Replicated Immediate SIMD ALU

This block is one execution slice of a vector unit. It takes a 128-bit source vector and a short immediate from the instruction word. It copies the immediate into every lane of the chosen width, then applies a bitwise, arithmetic or compare operation to every lane at once. Three lane widths are supported: eight 16-bit halfwords, four 32-bit words and sixteen 8-bit bytes.

Word and halfword forms take a 10-bit signed immediate and sign-extend it to the lane width. Byte forms take a separate 8-bit immediate. A load-address form writes an 18-bit immediate, zero-extended, into all four words. Compares produce a mask for each lane. The result is registered, so it appears one clock after the request is accepted.

Top module: `imm_lane_alu`

## Requirements
- R1: `out_valid` is high exactly one clock after `in_valid` was high, and low one clock after `in_valid` was low. `result` and `illegal_op` are updated at that same edge.
- R2: For op_sel 0/1 (OR word/half), 3/4 (AND word/half) and 6/7 (XOR word/half), `imm10` is sign-extended to 32 or 16 bits, copied into every lane, and combined bitwise with `src_vec`.
- R3: For op_sel 2, 5 and 8 (OR, AND, XOR on bytes), `imm8` is copied into all 16 byte lanes and combined bitwise with `src_vec`. `imm10` is ignored.
- R4: For op_sel 9 (word) and 10 (halfword), each lane equals the source lane plus the sign-extended `imm10`, modulo the lane width, with no carry into the neighbouring lane.
- R5: For op_sel 11 (word) and 12 (halfword), each lane equals the sign-extended `imm10` minus the source lane, modulo the lane width.
- R6: For op_sel 13 (word), 14 (halfword) and 15 (byte, using `imm8`), a lane is all ones when the source lane, taken as signed, is greater than the signed immediate, and all zeros otherwise.
- R7: For op_sel 16 (word), 17 (halfword) and 18 (byte, using `imm8`), a lane is all ones when the source lane equals the immediate, and all zeros otherwise.
- R8: For op_sel 19, each of the four 32-bit words of `result` equals `load_imm` zero-extended to 32 bits. `src_vec` is ignored.
- R9: An accepted op_sel of 20 to 31 yields `result` of all zeros and raises `illegal_op` together with `out_valid`, for that cycle only.
- R10: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 5 | Operation and lane-width select |
| src_vec | input | 128 | Source vector |
| imm10 | input | 10 | Signed immediate for word and halfword forms |
| imm8 | input | 8 | Immediate for byte forms |
| load_imm | input | 18 | Unsigned immediate for the load-address form |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Registered result vector |
| illegal_op | output | 1 | Unsupported op_sel was accepted |

## Verification
Every result is due exactly one clock after its request is accepted. The driver applies inputs on falling edges and records the expected vector in a queue. On each later falling edge, the monitor checks that `out_valid` is high only when an entry is pending, then pops that entry and compares it. Requests are issued both back to back and with gaps. During gaps, the bench checks that the held `result` still matches the last expected value.

// File: rtl/imm_lane_alu.sv
module imm_lane_alu #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       op_sel,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [9:0]       imm10,
  input  logic [7:0]       imm8,
  input  logic [17:0]      load_imm,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic             illegal_op
);
  localparam int NW = VEC_W / 32;
  localparam int NH = VEC_W / 16;
  localparam int NB = VEC_W / 8;

  localparam logic [4:0] OP_OR_W = 5'd0,  OP_OR_H = 5'd1,  OP_OR_B = 5'd2;
  localparam logic [4:0] OP_AND_W = 5'd3, OP_AND_H = 5'd4, OP_AND_B = 5'd5;
  localparam logic [4:0] OP_XOR_W = 5'd6, OP_XOR_H = 5'd7, OP_XOR_B = 5'd8;
  localparam logic [4:0] OP_ADD_W = 5'd9, OP_ADD_H = 5'd10;
  localparam logic [4:0] OP_SBF_W = 5'd11, OP_SBF_H = 5'd12;
  localparam logic [4:0] OP_GT_W = 5'd13, OP_GT_H = 5'd14, OP_GT_B = 5'd15;
  localparam logic [4:0] OP_EQ_W = 5'd16, OP_EQ_H = 5'd17, OP_EQ_B = 5'd18;
  localparam logic [4:0] OP_LDA  = 5'd19;

  wire [31:0] imm_w = {{22{imm10[9]}}, imm10};
  wire [15:0] imm_h = {{6{imm10[9]}}, imm10};

  wire [VEC_W-1:0] rep_w = {NW{imm_w}};
  wire [VEC_W-1:0] rep_h = {NH{imm_h}};
  wire [VEC_W-1:0] rep_b = {NB{imm8}};
  wire [VEC_W-1:0] rep_a = {NW{{14'd0, load_imm}}};

  logic [VEC_W-1:0] add_w, add_h, sbf_w, sbf_h;
  logic [VEC_W-1:0] gt_w, gt_h, gt_b, eq_w, eq_h, eq_b;

  genvar g;
  generate
    for (g = 0; g < NW; g++) begin : g_word
      wire [31:0] a = src_vec[VEC_W-1-32*g -: 32];
      assign add_w[VEC_W-1-32*g -: 32] = a + imm_w;
      assign sbf_w[VEC_W-1-32*g -: 32] = imm_w - a;
      assign gt_w[VEC_W-1-32*g -: 32]  = {32{$signed(a) > $signed(imm_w)}};
      assign eq_w[VEC_W-1-32*g -: 32]  = {32{a == imm_w}};
    end
    for (g = 0; g < NH; g++) begin : g_half
      wire [15:0] a = src_vec[VEC_W-1-16*g -: 16];
      assign add_h[VEC_W-1-16*g -: 16] = a + imm_h;
      assign sbf_h[VEC_W-1-16*g -: 16] = imm_h - a;
      assign gt_h[VEC_W-1-16*g -: 16]  = {16{$signed(a) > $signed(imm_h)}};
      assign eq_h[VEC_W-1-16*g -: 16]  = {16{a == imm_h}};
    end
    for (g = 0; g < NB; g++) begin : g_byte
      wire [7:0] a = src_vec[VEC_W-1-8*g -: 8];
      assign gt_b[VEC_W-1-8*g -: 8] = {8{$signed(a) > $signed(imm8)}};
      assign eq_b[VEC_W-1-8*g -: 8] = {8{a == imm8}};
    end
  endgenerate

  logic [VEC_W-1:0] nxt;
  logic             bad;

  always_comb begin
    bad = 1'b0;
    case (op_sel)
      OP_OR_W:  nxt = src_vec | rep_w;
      OP_OR_H:  nxt = src_vec | rep_h;
      OP_OR_B:  nxt = src_vec | rep_b;
      OP_AND_W: nxt = src_vec & rep_w;
      OP_AND_H: nxt = src_vec & rep_h;
      OP_AND_B: nxt = src_vec & rep_b;
      OP_XOR_W: nxt = src_vec ^ rep_w;
      OP_XOR_H: nxt = src_vec ^ rep_h;
      OP_XOR_B: nxt = src_vec ^ rep_b;
      OP_ADD_W: nxt = add_w;
      OP_ADD_H: nxt = add_h;
      OP_SBF_W: nxt = sbf_w;
      OP_SBF_H: nxt = sbf_h;
      OP_GT_W:  nxt = gt_w;
      OP_GT_H:  nxt = gt_h;
      OP_GT_B:  nxt = gt_b;
      OP_EQ_W:  nxt = eq_w;
      OP_EQ_H:  nxt = eq_h;
      OP_EQ_B:  nxt = eq_b;
      OP_LDA:   nxt = rep_a;
      default: begin
        nxt = '0;
        bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      illegal_op <= in_valid & bad;
      if (in_valid) result <= nxt;
    end
  end
endmodule

module imm_lane_alu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [4:0]   op_sel,
  input logic [127:0] src_vec,
  input logic [17:0]  load_imm,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         illegal_op
);
  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (out_valid && result == '0));
  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel >= 5'd20) |=> illegal_op);
  assert_or_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 5'd0) |=> ((result & $past(src_vec)) == $past(src_vec)));
  assert_lda_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 5'd19) |=> (result == {4{14'd0, $past(load_imm)}}));

  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_mask
      assert_eq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 5'd16) |=>
          (result[32*k +: 32] == 32'd0 || result[32*k +: 32] == 32'hFFFF_FFFF));
    end
  endgenerate
endmodule

bind imm_lane_alu imm_lane_alu_chk u_chk (.*);

// File: tb/sim_imm_lane_alu.sv
module sim_imm_lane_alu;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic [4:0]   op_sel = 0;
  logic [127:0] src_vec = 0;
  logic [9:0]   imm10 = 0;
  logic [7:0]   imm8 = 0;
  logic [17:0]  load_imm = 0;
  logic         out_valid;
  logic [127:0] result;
  logic         illegal_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [127:0] res;
    logic         ill;
    string        tag;
  } exp_t;
  exp_t sbq[$];
  logic [127:0] last_res = 0;

  always #10 clk = ~clk;

  imm_lane_alu u0 (.*);

  function automatic logic [127:0] model(input logic [4:0] op, input logic [127:0] s,
      input logic [9:0] i10, input logic [7:0] i8, input logic [17:0] ia);
    logic [127:0] r;
    logic [31:0] iw;
    logic [15:0] ih;
    iw = 32'($signed(i10));
    ih = 16'($signed(i10));
    r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a;
      a = s[32*k +: 32];
      case (op)
        0: r[32*k +: 32] = a | iw;
        3: r[32*k +: 32] = a & iw;
        6: r[32*k +: 32] = a ^ iw;
        9: r[32*k +: 32] = a + iw;
        11: r[32*k +: 32] = iw - a;
        13: r[32*k +: 32] = ($signed(a) > $signed(iw)) ? '1 : '0;
        16: r[32*k +: 32] = (a == iw) ? '1 : '0;
        19: r[32*k +: 32] = {14'd0, ia};
        default: ;
      endcase
    end
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      a = s[16*k +: 16];
      case (op)
        1: r[16*k +: 16] = a | ih;
        4: r[16*k +: 16] = a & ih;
        7: r[16*k +: 16] = a ^ ih;
        10: r[16*k +: 16] = a + ih;
        12: r[16*k +: 16] = ih - a;
        14: r[16*k +: 16] = ($signed(a) > $signed(ih)) ? '1 : '0;
        17: r[16*k +: 16] = (a == ih) ? '1 : '0;
        default: ;
      endcase
    end
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a;
      a = s[8*k +: 8];
      case (op)
        2: r[8*k +: 8] = a | i8;
        5: r[8*k +: 8] = a & i8;
        8: r[8*k +: 8] = a ^ i8;
        15: r[8*k +: 8] = ($signed(a) > $signed(i8)) ? '1 : '0;
        18: r[8*k +: 8] = (a == i8) ? '1 : '0;
        default: ;
      endcase
    end
    return r;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [127:0] s, input logic [9:0] i10,
      input logic [7:0] i8, input logic [17:0] ia, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1; op_sel = op; src_vec = s; imm10 = i10; imm8 = i8; load_imm = ia;
    e.res = model(op, s, i10, i8, ia);
    e.ill = (op >= 20);
    e.tag = tag;
    sbq.push_back(e);
    last_res = e.res;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      src_vec = {4{32'hDEAD_BEEF}};
      op_sel = 5'd0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL R1: out_valid=1 with nothing pending, expected 0");
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (result !== e.res || illegal_op !== e.ill) begin
          errors++;
          $display("FAIL %s: result=%h ill=%b expected %h ill=%b", e.tag, result, illegal_op, e.res, e.ill);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || result !== '0 || illegal_op !== 0) begin
      errors++;
      $display("FAIL R1 reset: v=%b r=%h i=%b expected 0 0 0", out_valid, result, illegal_op);
    end
    @(negedge clk); rst_n = 1;

    drive(0, 128'h0000_0001_1234_5678_8000_0000_0000_0000, 10'h3F0, 8'h00, 0, "R2 or word neg");
    drive(1, 128'h0, 10'h155, 8'h00, 0, "R2 or half");
    drive(4, {8{16'hFFFF}}, 10'h2AA, 8'h00, 0, "R2 and half neg");
    drive(6, {4{32'h0F0F_0F0F}}, 10'h1FF, 8'h00, 0, "R2 xor word");
    drive(2, 128'h0, 10'h3FF, 8'hA5, 0, "R3 or byte ignores imm10");
    drive(5, {16{8'h3C}}, 10'h000, 8'h0F, 0, "R3 and byte");
    drive(8, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 10'h155, 8'hFF, 0, "R3 xor byte");
    idle(2);
    checks++;
    if (result !== last_res) begin
      errors++;
      $display("FAIL R10 hold: result=%h expected %h", result, last_res);
    end
    drive(9, {32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h1}, 10'h001, 8'h00, 0, "R4 add word wrap");
    drive(9, {4{32'h0000_0005}}, 10'h3FF, 8'h00, 0, "R4 add word neg");
    drive(10, {8{16'hFFFF}}, 10'h001, 8'h00, 0, "R4 add half no carry");
    drive(11, {32'h1, 32'h0, 32'hFFFF_FFFF, 32'h10}, 10'h00A, 8'h00, 0, "R5 subf word");
    drive(12, {8{16'h0003}}, 10'h200, 8'h00, 0, "R5 subf half");
    drive(13, {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFF0, 32'h5}, 10'h3F0, 8'h00, 0, "R6 gt word signed");
    drive(14, {16'h0005, 16'h0004, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h0, 16'h0006, 16'h0003}, 10'h005, 8'h00, 0, "R6 gt half");
    drive(15, {16{8'h80}} | 128'h7F02_0100, 10'h000, 8'h01, 0, "R6 gt byte signed");
    drive(16, {32'hFFFF_FE00, 32'h0000_0200, 32'hFFFF_FE00, 32'h0}, 10'h200, 8'h00, 0, "R7 eq word");
    drive(17, {4{16'h01FF, 16'h01FE}}, 10'h1FF, 8'h00, 0, "R7 eq half");
    drive(18, 128'h00AA_AA00_AAAA_0000_0000_0000_0000_00AA, 10'h000, 8'hAA, 0, "R7 eq byte");
    drive(19, {4{32'hFFFF_FFFF}}, 10'h3FF, 8'hFF, 18'h3FFFF, "R8 load addr");
    drive(19, 128'h0, 10'h0, 8'h0, 18'h12345, "R8 load addr 2");
    drive(20, {4{32'hFFFF_FFFF}}, 10'h3FF, 8'hFF, 0, "R9 illegal 20");
    drive(0, 128'h0, 10'h001, 8'h00, 0, "R9 flag clears");
    drive(31, {4{32'h1234_5678}}, 10'h3FF, 8'hFF, 18'h3FFFF, "R9 illegal 31");
    idle(1);
    for (int i = 0; i < 60; i++) begin
      drive(5'($urandom_range(0, 21)), {$urandom, $urandom, $urandom, $urandom},
            10'($urandom), 8'($urandom), 18'($urandom), "R1 random mix");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, expected 0", sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule